// File: doc/BRIEF.md
# Vector Indexed Register Gather Unit

This block performs an indirect gather across a small register array that it holds itself. After a start request it walks the elements of a vector in order. For element i it fetches an index value from register rs1+i and checks that value against the vector length. If the index is in range, it copies register rs2+index into register rd+i. An index at or above the vector length halts the operation with a trap, and the trap reports the number of the failing element.

Register numbers wrap modulo the array size. Each element uses a fixed three-cycle sequence: index fetch, source fetch, destination write. Because the writes land in element order, an overlap between the destination and either source range behaves like sequential execution. While the unit is busy it also drives a mask of the source registers it may read, which a scheduler can use as a hazard reservation. The mask can optionally be widened to a power-of-two span. A separate access port loads and reads the array while the unit is idle.

Top module: `vgather_unit`

## Requirements
- R1: After reset, busy_o, done_o, trap_o, trap_elem_o and hazard_mask_o are all zero, and every register reads zero.
- R2: A start with vl_i equal to 0 asserts done_o after the start edge, keeps busy_o low, and writes no register.
- R3: For vl_i = n with no trap, register (rd+i) mod NREGS receives register (rs2+idx) mod NREGS for every i < n, where idx is the value of register (rs1+i) mod NREGS.
- R4: Each element takes three cycles. With no trap, done_o is seen 3·n clock edges after the start edge, and busy_o stays high until then.
- R5: An index value greater than or equal to vl_i sets trap_o and sets trap_elem_o to the element number k. done_o is then seen 3·k+1 edges after the start edge.
- R6: On a trap, element k and every later element write nothing, and elements below k keep their new values.
- R7: Elements are processed strictly in ascending order. Any index or source read by element i sees the writes of elements 0..i-1.
- R8: start_i is ignored while busy_o is high.
- R9: A write on the access port takes effect one edge later when the unit is idle, and is ignored while busy_o is high. acc_rdata_o combinationally shows register acc_raddr_i.
- R10: While busy_o is high, hazard_mask_o has bit r set exactly when (r − rs2) mod NREGS < span. span is vl, or with ROUND_POW2=1 the smallest power of two ≥ vl. While idle the mask is zero.
- R11: done_o is a one-cycle pulse. trap_o and trap_elem_o hold their values until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a gather (accepted when idle) |
| vl_i | input | $clog2(NREGS)+1 | Vector length, 0..NREGS |
| rs1_i | input | $clog2(NREGS) | Base register of the index vector |
| rs2_i | input | $clog2(NREGS) | Base register of the source vector |
| rd_i | input | $clog2(NREGS) | Base register of the destination vector |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Last operation ended on an out-of-range index |
| trap_elem_o | output | $clog2(NREGS)+1 | Element number that trapped |
| hazard_mask_o | output | NREGS | Source registers reserved while busy |
| acc_we_i | input | 1 | Access-port write enable |
| acc_waddr_i | input | $clog2(NREGS) | Access-port write register |
| acc_wdata_i | input | DW | Access-port write data |
| acc_raddr_i | input | $clog2(NREGS) | Access-port read register |
| acc_rdata_o | output | DW | Access-port read data |

## Verification
The bench builds the unit with NREGS=8, DW=4 and ROUND_POW2=1. With these values it can sweep every vector length from 0 to the full array and every pair of index and source bases, with a destination base that moves across the sweep. Array contents are generated so that some runs complete, some trap at various element numbers, and some have destination ranges that overlap the index or source ranges and wrap around the top of the array. Every run is compared against a sequential model register by register, along with completion cycle, trap element and reservation mask. A directed run checks start and access-port writes issued mid-operation.

// File: rtl/vgather_pkg.sv
package vgather_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IDX  = 2'd1,
    ST_SRC  = 2'd2,
    ST_WR   = 2'd3
  } vg_state_e;
endpackage

// File: rtl/vgather_rf.sv
module vgather_rf #(
  parameter int NREGS = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic [AW-1:0] int_raddr_i,
  output logic [DW-1:0] int_rdata_o,
  input  logic          int_we_i,
  input  logic [AW-1:0] int_waddr_i,
  input  logic [DW-1:0] int_wdata_i,
  input  logic          acc_we_i,
  input  logic [AW-1:0] acc_waddr_i,
  input  logic [DW-1:0] acc_wdata_i,
  input  logic [AW-1:0] acc_raddr_i,
  output logic [DW-1:0] acc_rdata_o
);
  logic [DW-1:0] regs_q [NREGS];
  logic          acc_ok;

  assign acc_ok = acc_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREGS; r++) regs_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        if (int_we_i && int_waddr_i == AW'(r)) regs_q[r] <= int_wdata_i;
        else if (acc_ok && acc_waddr_i == AW'(r)) regs_q[r] <= acc_wdata_i;
      end
    end
  end

  assign int_rdata_o = regs_q[int_raddr_i];
  assign acc_rdata_o = regs_q[acc_raddr_i];
endmodule

// File: rtl/vgather_hazard.sv
module vgather_hazard #(
  parameter int NREGS      = 16,
  parameter int AW         = $clog2(NREGS),
  parameter int VLW        = AW + 1,
  parameter bit ROUND_POW2 = 1'b1
) (
  input  logic             active_i,
  input  logic [AW-1:0]    base_i,
  input  logic [VLW-1:0]   len_i,
  output logic [NREGS-1:0] mask_o
);
  logic [VLW-1:0] span;

  generate
    if (ROUND_POW2) begin : g_round
      always_comb begin
        span = '0;
        if (len_i != '0) begin
          for (int k = AW; k >= 0; k--) begin
            if ((VLW'(1) << k) >= len_i) span = VLW'(1) << k;
          end
        end
      end
    end else begin : g_exact
      assign span = len_i;
    end
  endgenerate

  for (genvar r = 0; r < NREGS; r++) begin : g_bit
    logic [AW-1:0] off;
    assign off       = AW'(r) - base_i;
    assign mask_o[r] = active_i && ({1'b0, off} < span);
  end
endmodule

// File: rtl/vgather_ctrl.sv
module vgather_ctrl
  import vgather_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int VLW = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic [AW-1:0]  rs1_i,
  input  logic [AW-1:0]  rs2_i,
  input  logic [AW-1:0]  rd_i,
  output logic [AW-1:0]  rf_raddr_o,
  input  logic [DW-1:0]  rf_rdata_i,
  output logic           rf_we_o,
  output logic [AW-1:0]  rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           trap_o,
  output logic [VLW-1:0] trap_elem_o,
  output logic [VLW-1:0] vl_o,
  output logic [AW-1:0]  rs2_o
);
  localparam int CW = (DW > VLW) ? DW : VLW;

  vg_state_e      state_q;
  logic [VLW-1:0] elem_q, vl_q;
  logic [AW-1:0]  rs1_q, rs2_q, rd_q, idx_q;
  logic [DW-1:0]  data_q;
  logic           done_q, trap_q;
  logic [VLW-1:0] trap_elem_q;
  logic           idx_bad, last_elem;

  assign idx_bad   = CW'(rf_rdata_i) >= CW'(vl_q);
  assign last_elem = (elem_q == vl_q - VLW'(1));

  // index fetch and source fetch share the single internal read port
  assign rf_raddr_o = (state_q == ST_IDX) ? rs1_q + elem_q[AW-1:0] : rs2_q + idx_q;
  assign rf_we_o    = (state_q == ST_WR);
  assign rf_waddr_o = rd_q + elem_q[AW-1:0];
  assign rf_wdata_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      elem_q      <= '0;
      vl_q        <= '0;
      rs1_q       <= '0;
      rs2_q       <= '0;
      rd_q        <= '0;
      idx_q       <= '0;
      data_q      <= '0;
      done_q      <= 1'b0;
      trap_q      <= 1'b0;
      trap_elem_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vl_q        <= vl_i;
            rs1_q       <= rs1_i;
            rs2_q       <= rs2_i;
            rd_q        <= rd_i;
            elem_q      <= '0;
            trap_q      <= 1'b0;
            trap_elem_q <= '0;
            if (vl_i == '0) done_q <= 1'b1;
            else            state_q <= ST_IDX;
          end
        end
        ST_IDX: begin
          if (idx_bad) begin
            trap_q      <= 1'b1;
            trap_elem_q <= elem_q;
            done_q      <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            idx_q   <= AW'(rf_rdata_i);
            state_q <= ST_SRC;
          end
        end
        ST_SRC: begin
          data_q  <= rf_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: begin
          if (last_elem) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            elem_q  <= elem_q + VLW'(1);
            state_q <= ST_IDX;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign trap_o      = trap_q;
  assign trap_elem_o = trap_elem_q;
  assign vl_o        = vl_q;
  assign rs2_o       = rs2_q;
endmodule

// File: rtl/vgather_unit.sv
module vgather_unit #(
  parameter int NREGS      = 16,
  parameter int DW         = 8,
  parameter bit ROUND_POW2 = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [$clog2(NREGS):0]     vl_i,
  input  logic [$clog2(NREGS)-1:0]   rs1_i,
  input  logic [$clog2(NREGS)-1:0]   rs2_i,
  input  logic [$clog2(NREGS)-1:0]   rd_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       trap_o,
  output logic [$clog2(NREGS):0]     trap_elem_o,
  output logic [NREGS-1:0]           hazard_mask_o,
  input  logic                       acc_we_i,
  input  logic [$clog2(NREGS)-1:0]   acc_waddr_i,
  input  logic [DW-1:0]              acc_wdata_i,
  input  logic [$clog2(NREGS)-1:0]   acc_raddr_i,
  output logic [DW-1:0]              acc_rdata_o
);
  localparam int AW  = $clog2(NREGS);
  localparam int VLW = AW + 1;

  logic [AW-1:0]  rf_raddr, rf_waddr, rs2_q;
  logic [DW-1:0]  rf_rdata, rf_wdata;
  logic           rf_we;
  logic [VLW-1:0] vl_q;

  vgather_ctrl #(.AW(AW), .DW(DW), .VLW(VLW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .vl_i        (vl_i),
    .rs1_i       (rs1_i),
    .rs2_i       (rs2_i),
    .rd_i        (rd_i),
    .rf_raddr_o  (rf_raddr),
    .rf_rdata_i  (rf_rdata),
    .rf_we_o     (rf_we),
    .rf_waddr_o  (rf_waddr),
    .rf_wdata_o  (rf_wdata),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .trap_o      (trap_o),
    .trap_elem_o (trap_elem_o),
    .vl_o        (vl_q),
    .rs2_o       (rs2_q)
  );

  vgather_rf #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_o),
    .int_raddr_i (rf_raddr),
    .int_rdata_o (rf_rdata),
    .int_we_i    (rf_we),
    .int_waddr_i (rf_waddr),
    .int_wdata_i (rf_wdata),
    .acc_we_i    (acc_we_i),
    .acc_waddr_i (acc_waddr_i),
    .acc_wdata_i (acc_wdata_i),
    .acc_raddr_i (acc_raddr_i),
    .acc_rdata_o (acc_rdata_o)
  );

  vgather_hazard #(.NREGS(NREGS), .AW(AW), .VLW(VLW), .ROUND_POW2(ROUND_POW2)) u_haz (
    .active_i (busy_o),
    .base_i   (rs2_q),
    .len_i    (vl_q),
    .mask_o   (hazard_mask_o)
  );
endmodule

// File: rtl/vgather_unit_chk.sv
module vgather_unit_chk #(
  parameter int NREGS = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [$clog2(NREGS):0] vl_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   trap_o,
  input logic [NREGS-1:0]       hazard_mask_o
);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R5
  trap_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_o) |-> done_o);

  // R10
  mask_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (hazard_mask_o == '0));

  // R2
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && vl_i == '0) |=> (done_o && !busy_o));

  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind vgather_unit vgather_unit_chk #(.NREGS(NREGS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .vl_i          (vl_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .trap_o        (trap_o),
  .hazard_mask_o (hazard_mask_o)
);

// File: tb/vgather_unit_bench.sv
`timescale 1ns/1ps
module vgather_unit_bench;
  localparam int NREGS = 8;
  localparam int DW    = 4;
  localparam bit ROUND = 1'b1;
  localparam int AW    = $clog2(NREGS);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [AW:0]      vl_i = '0;
  logic [AW-1:0]    rs1_i = '0, rs2_i = '0, rd_i = '0;
  logic             busy_o, done_o, trap_o;
  logic [AW:0]      trap_elem_o;
  logic [NREGS-1:0] hazard_mask_o;
  logic             acc_we_i = 1'b0;
  logic [AW-1:0]    acc_waddr_i = '0, acc_raddr_i = '0;
  logic [DW-1:0]    acc_wdata_i = '0;
  logic [DW-1:0]    acc_rdata_o;

  int n_chk = 0;
  int n_err = 0;
  int m[NREGS];

  always #5 clk = ~clk;

  vgather_unit #(.NREGS(NREGS), .DW(DW), .ROUND_POW2(ROUND)) u_vgather_unit (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .vl_i(vl_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .rd_i(rd_i), .busy_o(busy_o), .done_o(done_o),
    .trap_o(trap_o), .trap_elem_o(trap_elem_o), .hazard_mask_o(hazard_mask_o),
    .acc_we_i(acc_we_i), .acc_waddr_i(acc_waddr_i), .acc_wdata_i(acc_wdata_i),
    .acc_raddr_i(acc_raddr_i), .acc_rdata_o(acc_rdata_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mask(input int vl, input int base);
    int span = 0;
    int res = 0;
    if (vl > 0) begin
      span = vl;
      if (ROUND) begin
        span = 1;
        while (span < vl) span = span * 2;
      end
    end
    for (int r = 0; r < NREGS; r++)
      if (((r - base + NREGS) % NREGS) < span) res |= (1 << r);
    return res;
  endfunction

  task automatic load_regs();
    for (int r = 0; r < NREGS; r++) begin
      @(negedge clk);
      acc_we_i = 1'b1; acc_waddr_i = AW'(r); acc_wdata_i = DW'(m[r]);
    end
    @(negedge clk);
    acc_we_i = 1'b0;
  endtask

  task automatic verify_regs(input string req);
    for (int r = 0; r < NREGS; r++) begin
      acc_raddr_i = AW'(r);
      #1;
      check(acc_rdata_o == DW'(m[r]), req, acc_rdata_o, m[r]);
    end
  endtask

  // sequential reference: fills m in place, returns trap element or -1
  function automatic int model(input int vl, input int s1, input int s2, input int d);
    for (int i = 0; i < vl; i++) begin
      int idx = m[(s1 + i) % NREGS];
      if (idx >= vl) return i;
      m[(d + i) % NREGS] = m[(s2 + idx) % NREGS];
    end
    return -1;
  endfunction

  // inject: mid-run start and access write to register 7 (R8, R9)
  task automatic run(input int vl, input int s1, input int s2, input int d, input bit inject);
    int tr, cyc, exp_cyc, keep7;
    bit ovl;
    string req;
    load_regs();
    keep7 = m[7];
    tr = model(vl, s1, s2, d);
    exp_cyc = (vl == 0) ? 0 : (tr < 0 ? 3 * vl : 3 * tr + 1);
    ovl = 1'b0;
    for (int i = 0; i < vl; i++)
      if (((d - s2 + NREGS) % NREGS) < vl || ((d - s1 + NREGS) % NREGS) < vl) ovl = 1'b1;
    @(negedge clk);
    start_i = 1'b1; vl_i = (AW+1)'(vl); rs1_i = AW'(s1); rs2_i = AW'(s2); rd_i = AW'(d);
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    if (vl > 0) begin
      check(busy_o == 1'b1, "R4", busy_o, 1);
      check(hazard_mask_o == NREGS'(exp_mask(vl, s2)), "R10", hazard_mask_o, exp_mask(vl, s2));
    end else begin
      check(busy_o == 1'b0, "R2", busy_o, 0);
    end
    while (!done_o && cyc < 200) begin
      if (inject && cyc == 2) begin
        start_i = 1'b1; vl_i = '0; acc_we_i = 1'b1; acc_waddr_i = 3'd7; acc_wdata_i = 4'd5;
      end else begin
        start_i = 1'b0; acc_we_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0; acc_we_i = 1'b0;
    check(cyc == exp_cyc, inject ? "R8" : (tr >= 0 ? "R5" : "R4"), cyc, exp_cyc);
    check(trap_o == (tr >= 0), "R5", trap_o, tr >= 0);
    if (tr >= 0) check(trap_elem_o == (AW+1)'(tr), "R5", trap_elem_o, tr);
    check(busy_o == 1'b0, "R4", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R11", done_o, 0);
    check(trap_o == (tr >= 0), "R11", trap_o, tr >= 0);
    check(hazard_mask_o == '0, "R10", hazard_mask_o, 0);
    if (inject) begin
      acc_raddr_i = 3'd7; #1;
      check(acc_rdata_o == DW'(m[7]) && m[7] == keep7, "R9", acc_rdata_o, keep7);
    end
    req = (vl == 0) ? "R2" : (tr >= 0 ? "R6" : (ovl ? "R7" : "R3"));
    verify_regs(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", {busy_o, done_o}, 0);
    check(trap_o == 1'b0 && trap_elem_o == '0, "R1", trap_o, 0);
    check(hazard_mask_o == '0, "R1", hazard_mask_o, 0);
    for (int r = 0; r < NREGS; r++) m[r] = 0;
    verify_regs("R1");
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 idle access writes land
    for (int r = 0; r < NREGS; r++) m[r] = (r * 7 + 3) % 16;
    load_regs();
    verify_regs("R9");

    // R8 / R9 directed: mid-run start and access write are ignored
    m[0] = 3; m[1] = 0; m[2] = 2; m[3] = 1;
    m[4] = 9; m[5] = 10; m[6] = 11; m[7] = 12;
    run(4, 0, 4, 0, 1'b1);

    // R7 explicit overlap: destination slides over the index vector
    for (int r = 0; r < NREGS; r++) m[r] = (r + 1) % 4;
    run(4, 0, 0, 1, 1'b0);

    // sweep: every vl, every rs1, every rs2, moving rd
    for (int vl = 0; vl <= NREGS; vl++)
      for (int s1 = 0; s1 < NREGS; s1++)
        for (int s2 = 0; s2 < NREGS; s2++) begin
          int d = (s1 * 3 + s2 + vl) % NREGS;
          for (int r = 0; r < NREGS; r++)
            m[r] = (r * 3 + s1 + 5 * s2 + 7 * vl) % (vl + 2);
          run(vl, s1, s2, d, 1'b0);
        end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule